// File: doc/BRIEF.md
# Flash Page Program Controller

This controller sits between a byte-wide processor bus and a small modelled flash array. It walks software through the page program and verify sequence. It collects one page of eight bytes in a staging buffer. It raises a high-voltage enable only after a set of interlocks has passed. It commits the page to the array once the enable has stayed high long enough. Array reads made in verify mode take longer than normal reads. Configurable cycle counts stand in for the analog settling times between steps. Any step taken out of order, or taken before its wait has run out, is refused and recorded in sticky status bits.

The bus is a valid/ready channel. The requester raises `bus_valid` together with the command fields. It must hold all of them steady until it sees `bus_ready` high at a rising clock edge, and that edge completes the access. Writes, register reads and normal array reads complete in the cycle `bus_valid` first rises. Array reads made while the verify bit is set are held back by keeping `bus_ready` low. Read data on `bus_rdata` is valid in the completing cycle.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, `hv_on` is low, and every array byte reads 0xFF.
- R2: Every write, every register read and every array read made while verify (control bit 2) is clear completes in one cycle. An array read made while verify is set keeps `bus_ready` low for STRETCH (8) cycles and completes in the ninth cycle.
- R3: While programming, the first accepted array write picks the page: its address with the low 3 bits cleared. Later writes to other pages set the sequence error and are dropped. The array itself keeps its old contents until the commit.
- R4: A read of register offset 1 returns `lock_map`. Reading it while program-enable is set arms the sequence and latches `lock_map`. Array writes or a high-voltage request made before this read set the sequence error and are refused.
- R5: With a block size of 2^ADDR_W/PROT_W bytes, the page sits in block n, given by the page's top log2(PROT_W) address bits. If latched bit n is set, a high-voltage request clears all control bits, sets status bit 2, and leaves `hv_on` low and the array unchanged. A latched value of zero blocks nothing.
- R6: A high-voltage request (setting control bit 1) is accepted only when all eight bytes of the page have been written. Otherwise it sets the sequence error.
- R7: `hv_on` follows control bit 1. Clearing that bit after it has been high for at least T_PROG cycles writes the eight staged bytes into the array.
- R8: Clearing control bit 1 before T_PROG cycles have passed sets the timing error (status bit 1) and clears all control bits. The array stays unchanged.
- R9: Setting verify is accepted only after a program commit and at least T_HVTV cycles later. Clearing program-enable while verify is set needs T_VTP cycles. Any other verify set, and any verify read made with program-enable still set, sets the sequence error and is refused.
- R10: A control write that changes more than one bit is refused and sets the sequence error.
- R11: Status bits 0 (sequence error), 1 (timing error) and 2 (protected page) are sticky. Each is cleared by writing 1 to it at register offset 2. `seq_err` and `time_err` mirror bits 0 and 1.
- R12: Status reads, lock reads and array reads made between steps, and array writes made while program-enable is clear, leave the sequence and the array untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Access request valid |
| bus_ready | output | 1 | Access completes at this edge |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_regsel | input | 1 | 1 = register space (offsets 0 ctrl, 1 lock, 2 status), 0 = array |
| bus_addr | input | ADDR_W | Byte address or register offset (low 2 bits) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| lock_map | input | PROT_W | Stored block-protect value, one bit per block |
| hv_on | output | 1 | High voltage applied to the array |
| seq_err | output | 1 | Sticky sequence error |
| time_err | output | 1 | Sticky timing error |

## Verification
On every cycle, the assertions check four things. High voltage can rise only with a full page and an unlocked block. Verify can only follow a program. A stretched verify read completes only after a stall. The staged page address never moves once chosen. Other behaviour needs the bench's ordered scenarios to show. That covers the committed contents after a full sequence and the array left unchanged after early clears and protected pages. It also covers the nine-cycle length of each verify read, the refusal of misordered or multi-bit control writes, and the clearing of sticky flags.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_LOAD, S_HV, S_HVOFF, S_VFY, S_PGOFF
  } seq_state_e;

  localparam int PAGE_BYTES = 8;
  localparam int PAGE_LSB   = 3;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_LOCK = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;

  localparam int CB_PROG = 0;
  localparam int CB_HV   = 1;
  localparam int CB_VFY  = 2;

  localparam int SB_SEQ  = 0;
  localparam int SB_TIME = 1;
  localparam int SB_LOCK = 2;
endpackage

// File: rtl/fpc_page_buf.sv
module fpc_page_buf
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_i,
  input  logic                         wr_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [7:0]                   data_i,
  output logic                         hit_o,
  output logic                         full_o,
  output logic [ADDR_W-PAGE_LSB-1:0]   page_o,
  output logic [PAGE_BYTES*8-1:0]      data_o
);
  localparam int PG_W = ADDR_W - PAGE_LSB;

  logic                  valid_q;
  logic [PG_W-1:0]       page_q;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [7:0]            bytes_q [PAGE_BYTES];

  assign hit_o  = !valid_q || (addr_i[ADDR_W-1:PAGE_LSB] == page_q);
  assign full_o = &mask_q;
  assign page_o = page_q;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
    assign data_o[g*8 +: 8] = bytes_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      page_q  <= '0;
      mask_q  <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) bytes_q[i] <= 8'hFF;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      mask_q  <= '0;
    end else if (wr_i && hit_o) begin
      valid_q                      <= 1'b1;
      page_q                       <= addr_i[ADDR_W-1:PAGE_LSB];
      mask_q[addr_i[PAGE_LSB-1:0]]  <= 1'b1;
      bytes_q[addr_i[PAGE_LSB-1:0]] <= data_i;
    end
  end

  assert_page_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !clr_i) |=> $stable(page_q));
endmodule

// File: rtl/fpc_array.sv
module fpc_array
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           raddr_i,
  output logic [7:0]                  rdata_o,
  input  logic                        commit_i,
  input  logic [ADDR_W-PAGE_LSB-1:0]  page_i,
  input  logic [PAGE_BYTES*8-1:0]     data_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] mem [DEPTH];

  assign rdata_o = mem[raddr_i];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (commit_i) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        mem[{page_i, PAGE_LSB'(i)}] <= data_i[i*8 +: 8];
    end
  end
endmodule

// File: rtl/fpc_seq.sv
module fpc_seq
  import flash_prog_pkg::*;
#(
  parameter int PROT_W = 8,
  parameter int TW     = 16,
  parameter int T_PROG = 20,
  parameter int T_HVTV = 4,
  parameter int T_VTP  = 4,
  parameter int T_HVD  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ctl_wr_i,
  input  logic                       stat_wr_i,
  input  logic [2:0]                 wbits_i,
  input  logic                       lock_rd_i,
  input  logic [PROT_W-1:0]          lock_map_i,
  input  logic                       arr_wr_i,
  input  logic                       vfy_rd_i,
  input  logic                       page_hit_i,
  input  logic                       page_full_i,
  input  logic [$clog2(PROT_W)-1:0]  blk_i,
  output logic [2:0]                 ctl_o,
  output logic [2:0]                 stat_o,
  output logic                       buf_wr_o,
  output logic                       buf_clr_o,
  output logic                       commit_o
);
  localparam logic [TW-1:0] TMAX = '1;

  seq_state_e          state_q, nxt;
  logic [TW-1:0]       tmr_q;
  logic [PROT_W-1:0]   lock_q;
  logic [2:0]          stat_q;
  logic                seq_set, time_set, lock_set, lock_ld;
  logic [2:0]          chg;
  logic                lock_hit;

  assign ctl_o[CB_PROG] = (state_q == S_ARMED) || (state_q == S_LOAD) ||
                          (state_q == S_HV) || (state_q == S_HVOFF) ||
                          (state_q == S_VFY);
  assign ctl_o[CB_HV]   = (state_q == S_HV);
  assign ctl_o[CB_VFY]  = (state_q == S_VFY) || (state_q == S_PGOFF);
  assign stat_o         = stat_q;
  assign chg            = wbits_i ^ ctl_o;
  assign lock_hit       = lock_q[blk_i];

  always_comb begin
    nxt       = state_q;
    seq_set   = 1'b0;
    time_set  = 1'b0;
    lock_set  = 1'b0;
    lock_ld   = 1'b0;
    commit_o  = 1'b0;
    buf_clr_o = 1'b0;
    buf_wr_o  = 1'b0;
    if (ctl_wr_i && (chg != 3'b000)) begin
      if ($countones(chg) > 1) begin
        seq_set = 1'b1;
      end else if (chg[CB_PROG]) begin
        if (wbits_i[CB_PROG]) begin
          if (state_q == S_IDLE) begin
            nxt = S_ARMED; buf_clr_o = 1'b1;
          end else seq_set = 1'b1;
        end else begin
          case (state_q)
            S_ARMED, S_LOAD: nxt = S_IDLE;
            S_VFY: if (tmr_q >= TW'(T_VTP)) nxt = S_PGOFF; else seq_set = 1'b1;
            default: seq_set = 1'b1;
          endcase
        end
      end else if (chg[CB_HV]) begin
        if (wbits_i[CB_HV]) begin
          if (state_q == S_LOAD && page_full_i) begin
            if (lock_hit) begin nxt = S_IDLE; lock_set = 1'b1; end
            else nxt = S_HV;
          end else seq_set = 1'b1;
        end else if (tmr_q >= TW'(T_PROG)) begin
          nxt = S_HVOFF; commit_o = 1'b1;
        end else begin
          nxt = S_IDLE; time_set = 1'b1;
        end
      end else begin
        if (wbits_i[CB_VFY]) begin
          if (state_q == S_HVOFF && tmr_q >= TW'(T_HVTV)) nxt = S_VFY;
          else seq_set = 1'b1;
        end else begin
          if (state_q == S_PGOFF) nxt = S_IDLE; else seq_set = 1'b1;
        end
      end
    end
    if (arr_wr_i) begin
      case (state_q)
        S_LOAD: if (page_hit_i) buf_wr_o = 1'b1; else seq_set = 1'b1;
        S_ARMED, S_HV, S_HVOFF, S_VFY: seq_set = 1'b1;
        default: ;
      endcase
    end
    if (lock_rd_i && (state_q == S_ARMED || state_q == S_LOAD)) begin
      lock_ld = 1'b1;
      nxt     = S_LOAD;
    end
    if (vfy_rd_i && (state_q == S_VFY || (state_q == S_PGOFF && tmr_q < TW'(T_HVD))))
      seq_set = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      lock_q  <= '0;
      stat_q  <= '0;
    end else begin
      state_q <= nxt;
      if (nxt != state_q) tmr_q <= TW'(1);
      else if (tmr_q != TMAX) tmr_q <= tmr_q + 1'b1;
      if (lock_ld) lock_q <= lock_map_i;
      stat_q <= (stat_q & ~(stat_wr_i ? wbits_i : 3'b000)) |
                {lock_set, time_set, seq_set};
    end
  end

  assert_hv_full_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o[CB_HV]) |-> $past(page_full_i));
  assert_hv_unlocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o[CB_HV]) |-> !$past(lock_hit));
  assert_vfy_after_prog_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o[CB_VFY]) |-> $past(state_q == S_HVOFF));
endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_prog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int PROT_W  = 8,
  parameter int STRETCH = 8,
  parameter int TW      = 16,
  parameter int T_PROG  = 20,
  parameter int T_HVTV  = 4,
  parameter int T_VTP   = 4,
  parameter int T_HVD   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic              bus_regsel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [PROT_W-1:0] lock_map,
  output logic              hv_on,
  output logic              seq_err,
  output logic              time_err
);
  localparam int PG_W  = ADDR_W - PAGE_LSB;
  localparam int BLK_W = $clog2(PROT_W);
  localparam int SW    = $clog2(STRETCH + 1);

  logic [2:0]              ctl, stat;
  logic                    acc, vfy_rd_req;
  logic                    ctl_wr, stat_wr, lock_rd, arr_wr, vfy_rd;
  logic                    buf_wr, buf_clr, commit;
  logic                    page_hit, page_full;
  logic [PG_W-1:0]         page;
  logic [PAGE_BYTES*8-1:0] page_data;
  logic [7:0]              arr_rdata;
  logic [SW-1:0]           str_q;

  assign vfy_rd_req = bus_valid && !bus_write && !bus_regsel && ctl[CB_VFY];
  assign bus_ready  = !vfy_rd_req || (str_q == SW'(STRETCH));
  assign acc        = bus_valid && bus_ready;
  assign ctl_wr     = acc && bus_write && bus_regsel && bus_addr[1:0] == REG_CTRL;
  assign stat_wr    = acc && bus_write && bus_regsel && bus_addr[1:0] == REG_STAT;
  assign lock_rd    = acc && !bus_write && bus_regsel && bus_addr[1:0] == REG_LOCK;
  assign arr_wr     = acc && bus_write && !bus_regsel;
  assign vfy_rd     = acc && vfy_rd_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) str_q <= '0;
    else if (vfy_rd_req && str_q != SW'(STRETCH)) str_q <= str_q + 1'b1;
    else str_q <= '0;
  end

  always_comb begin
    bus_rdata = arr_rdata;
    if (bus_regsel) begin
      case (bus_addr[1:0])
        REG_CTRL: bus_rdata = {5'b0, ctl};
        REG_LOCK: bus_rdata = 8'(lock_map);
        REG_STAT: bus_rdata = {5'b0, stat};
        default:  bus_rdata = 8'h00;
      endcase
    end
  end

  assign hv_on    = ctl[CB_HV];
  assign seq_err  = stat[SB_SEQ];
  assign time_err = stat[SB_TIME];

  fpc_seq #(
    .PROT_W(PROT_W), .TW(TW), .T_PROG(T_PROG),
    .T_HVTV(T_HVTV), .T_VTP(T_VTP), .T_HVD(T_HVD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr_i(ctl_wr), .stat_wr_i(stat_wr), .wbits_i(bus_wdata[2:0]),
    .lock_rd_i(lock_rd), .lock_map_i(lock_map),
    .arr_wr_i(arr_wr), .vfy_rd_i(vfy_rd),
    .page_hit_i(page_hit), .page_full_i(page_full),
    .blk_i(page[PG_W-1 -: BLK_W]),
    .ctl_o(ctl), .stat_o(stat),
    .buf_wr_o(buf_wr), .buf_clr_o(buf_clr), .commit_o(commit)
  );

  fpc_page_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr_i(buf_clr), .wr_i(buf_wr),
    .addr_i(bus_addr), .data_i(bus_wdata),
    .hit_o(page_hit), .full_o(page_full), .page_o(page), .data_o(page_data)
  );

  fpc_array #(.ADDR_W(ADDR_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .raddr_i(bus_addr), .rdata_o(arr_rdata),
    .commit_i(commit), .page_i(page), .data_i(page_data)
  );

  assert_commit_under_hv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> hv_on);
  assert_vfy_read_stalled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_rd_req && bus_ready) |-> $past(bus_valid && !bus_ready));
endmodule

// File: tb/flash_prog_ctrl_tb.sv
`timescale 1ns/1ps
module flash_prog_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_valid = 1'b0, bus_write = 1'b0, bus_regsel = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0, lock_map = '0;
  logic       bus_ready, hv_on, seq_err, time_err;
  logic [7:0] bus_rdata;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_prog_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_regsel(bus_regsel), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_map(lock_map),
    .hv_on(hv_on), .seq_err(seq_err), .time_err(time_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit w, input bit rs, input logic [7:0] a,
                      input logic [7:0] d, output logic [7:0] rd, output int n);
    bit r;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = w; bus_regsel = rs; bus_addr = a; bus_wdata = d;
    n = 0;
    do begin
      #1; r = bus_ready; rd = bus_rdata; n++;
      @(posedge clk);
      if (!r) @(negedge clk);
    end while (!r);
    #1 bus_valid = 1'b0;
  endtask

  task automatic wr(input bit rs, input logic [7:0] a, input logic [7:0] d);
    logic [7:0] x; int n;
    xfer(1'b1, rs, a, d, x, n);
  endtask

  task automatic rd(input bit rs, input logic [7:0] a, output logic [7:0] v, output int n);
    xfer(1'b0, rs, a, 8'h00, v, n);
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic load_page(input logic [7:0] base, input logic [7:0] seed);
    logic [7:0] v; int n;
    wr(1, 0, 8'h01);
    rd(1, 1, v, n);
    for (int i = 0; i < 8; i++) wr(0, base + 8'(i), seed + 8'(i));
  endtask

  task automatic t_reset;
    logic [7:0] v; int n;
    rd(1, 0, v, n); check("R1 ctrl", v, 0);
    rd(1, 2, v, n); check("R1 status", v, 0);
    check("R1 hv_on", hv_on, 0);
    rd(0, 8'h33, v, n); check("R1 array erased", v, 8'hFF);
    check("R2 normal read cycles", n, 1);
  endtask

  task automatic t_full;
    logic [7:0] v; int n;
    lock_map = 8'h00;
    load_page(8'h40, 8'h10);
    rd(1, 2, v, n); check("R12 status read mid-load", v, 0);
    rd(0, 8'h40, v, n); check("R3 array unchanged before commit", v, 8'hFF);
    wr(1, 0, 8'h03); check("R7 hv_on raised", hv_on, 1);
    rd(0, 8'h90, v, n); check("R12 unrelated read under hv", v, 8'hFF);
    idle(20);
    wr(1, 0, 8'h01); check("R7 hv_on dropped", hv_on, 0);
    idle(4); wr(1, 0, 8'h05);
    rd(1, 0, v, n); check("R9 verify accepted", v, 5);
    idle(4); wr(1, 0, 8'h04);
    rd(1, 0, v, n); check("R9 prog cleared", v, 4);
    idle(4);
    for (int i = 0; i < 8; i++) begin
      rd(0, 8'h40 + 8'(i), v, n);
      check("R7 committed byte", v, 8'h10 + i);
      check("R2 verify read cycles", n, 9);
    end
    wr(1, 0, 8'h00);
    rd(0, 8'h47, v, n); check("R2 normal read after verify", n, 1);
    rd(1, 2, v, n); check("R12 no error in clean flow", v, 0);
  endtask

  task automatic t_no_lock_read;
    logic [7:0] v; int n;
    wr(1, 0, 8'h01);
    wr(0, 8'h60, 8'hAA);
    check("R4 write before lock read flagged", seq_err, 1);
    wr(1, 0, 8'h03);
    check("R4 hv refused", hv_on, 0);
    rd(1, 0, v, n); check("R4 ctrl keeps prog only", v, 1);
    wr(1, 2, 8'h01);
    check("R11 w1c clears seq_err", seq_err, 0);
    wr(1, 0, 8'h00);
  endtask

  task automatic t_short_page;
    logic [7:0] v; int n;
    wr(1, 0, 8'h01); rd(1, 1, v, n);
    for (int i = 0; i < 7; i++) wr(0, 8'h68 + 8'(i), 8'h55);
    wr(1, 0, 8'h03);
    check("R6 partial page hv refused", hv_on, 0);
    check("R6 seq_err", seq_err, 1);
    wr(1, 0, 8'h00); wr(1, 2, 8'h01);
  endtask

  task automatic t_locked;
    logic [7:0] v; int n;
    lock_map = 8'h04;
    load_page(8'h48, 8'h20);
    wr(1, 0, 8'h03);
    check("R5 hv_on low", hv_on, 0);
    rd(1, 0, v, n); check("R5 ctrl cleared", v, 0);
    rd(1, 2, v, n); check("R5 status bit2", v, 4);
    rd(0, 8'h48, v, n); check("R5 array untouched", v, 8'hFF);
    wr(1, 2, 8'h04);
    rd(1, 2, v, n); check("R11 w1c bit2", v, 0);
    lock_map = 8'h00;
  endtask

  task automatic t_early;
    logic [7:0] v; int n;
    load_page(8'h08, 8'h77);
    wr(1, 0, 8'h03);
    idle(3);
    wr(1, 0, 8'h01);
    check("R8 time_err", time_err, 1);
    rd(1, 0, v, n); check("R8 ctrl cleared", v, 0);
    rd(0, 8'h08, v, n); check("R8 array unchanged", v, 8'hFF);
    wr(1, 2, 8'h02);
    check("R11 time_err cleared", time_err, 0);
  endtask

  task automatic t_outside;
    logic [7:0] v; int n;
    wr(1, 0, 8'h01); rd(1, 1, v, n);
    wr(0, 8'h10, 8'hC0);
    wr(0, 8'h20, 8'hEE);
    check("R3 off-page write flagged", seq_err, 1);
    for (int i = 1; i < 8; i++) wr(0, 8'h10 + 8'(i), 8'hC0 + 8'(i));
    wr(1, 0, 8'h03);
    check("R3 page still accepted", hv_on, 1);
    idle(20); wr(1, 0, 8'h01);
    wr(1, 0, 8'h05);
    rd(1, 0, v, n); check("R9 early verify refused", v, 1);
    idle(4); wr(1, 0, 8'h05); idle(4); wr(1, 0, 8'h04); idle(4); wr(1, 0, 8'h00);
    rd(0, 8'h20, v, n); check("R3 off-page byte not written", v, 8'hFF);
    rd(0, 8'h13, v, n); check("R3 on-page byte written", v, 8'hC3);
    wr(1, 2, 8'h01);
    wr(0, 8'h30, 8'h00);
    check("R12 write with prog clear ignored", seq_err, 0);
    rd(0, 8'h30, v, n); check("R12 array kept", v, 8'hFF);
  endtask

  task automatic t_bad_ctrl;
    logic [7:0] v; int n;
    wr(1, 0, 8'h04);
    check("R9 verify without program flagged", seq_err, 1);
    rd(1, 0, v, n); check("R9 verify stays clear", v, 0);
    wr(1, 2, 8'h01);
    wr(1, 0, 8'h03);
    check("R10 multi-bit flagged", seq_err, 1);
    rd(1, 0, v, n); check("R10 ctrl unchanged", v, 0);
    wr(1, 2, 8'h01);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_full();
    t_no_lock_read();
    t_short_page();
    t_locked();
    t_early();
    t_outside();
    t_bad_ctrl();
    done = 1'b1;
    report();
  end
endmodule